// File: doc/BRIEF.md
# Page-Tracking Next-Line Prefetcher

This block sits beside an L1 data cache and watches the stream of load and software-prefetch accesses. Each access arrives as a 64-byte line address, with an access kind, a page-dirty flag and a write-back flag. The block keeps a small fully associative table of recently touched 4 KB physical pages. It also keeps a 2-bit saturating counter for every cache set, where the set is the line's position inside its page.

When repeated traffic lands on one set, or on two neighbouring sets, the block fires a single trigger. That trigger turns into next-line prefetch requests, one for each tracked page. The requests are offered one per cycle to a fill-buffer allocator over a valid/ready pair. The allocator may refuse a request. A refused request is dropped, never queued, and the rest of that burst is abandoned with it. A flush input, driven when the TLB is flushed, forgets everything in one cycle.

Top module: `pg_nl_prefetch`

## Requirements
- R1: After reset no request is offered (`pf_valid` low), and the page table and all set counters are empty.
- R2: A qualifying access is one with kind load (0) or software prefetch (1), `acc_wb`=1 and `acc_dirty`=0. Hits and misses are not distinguished. A qualifying access increments the counter of set `acc_line[5:0]`. The third such access to one set (counter reaching 3) triggers with target set equal to that set plus one, and the counter returns to zero.
- R3: A trigger offers one request for each valid table entry, in ascending entry order. The address of each request is {entry page number, target set}. The first request is offered in the cycle after the clock edge that captured the triggering access, and each accepted request is followed by the next one in the following cycle.
- R4: If a same-set trigger would target beyond set 63, there is no trigger and no request.
- R5: An access can bring a set's count, added to a nonzero count in an adjacent set, to 3 or more. In that case the block triggers with target equal to the upper of the two sets, which is the next line after the lower set, and both counters return to zero. Any page whose most recent tracked access was to the target set is skipped, because a demand request for that line is already outstanding.
- R6: A qualifying access to an untracked page inserts it. Entries are replaced in round-robin order, starting from entry 0 after reset or flush.
- R7: Accesses with `acc_wb`=0, accesses of kind 3, and dirty accesses neither insert a page nor change any counter.
- R8: A write-back access with kind store (2) or with `acc_dirty`=1 invalidates the matching table entry, if there is one.
- R9: If a request is offered while `pf_ready` is low, that request and every remaining request of its burst are dropped.
- R10: A flush clears every table entry, every set counter, the replacement pointer and any burst in progress, all in one cycle. A trigger that arrives while a burst is still being offered is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Forget all tracked pages and counts |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_kind | input | 2 | 0 load, 1 software prefetch, 2 store, 3 other |
| acc_line | input | PA_W-6 | Physical line address of the access (page number above, set in low 6 bits) |
| acc_dirty | input | 1 | Page-dirty flag of the accessed page |
| acc_wb | input | 1 | Access is to write-back memory |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_ready | input | 1 | Fill-buffer allocator accepts the offered request |
| pf_line | output | PA_W-6 | Line address of the offered request |

## Verification
Exactly one register stands between an access and the first request it causes. The bench therefore drives each access on a falling edge and checks `pf_valid` and `pf_line` on the very next falling edge. Further requests of the same burst are checked on each following falling edge, with `pf_ready` held high. Cases that must produce nothing, such as the page-edge set, ignored kinds and accesses after a flush, are checked on those same falling edges. A refused request is checked at the falling edge after the refusing edge, where `pf_valid` must already be low.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
  localparam int LINE_OFS = 6;   // 64-byte lines
  localparam int PAGE_OFS = 12;  // 4 KB pages

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_SWPF  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_OTHER = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/pfx_set_ctrs.sv
// Per-set 2-bit saturating counters and trigger decision.
module pfx_set_ctrs #(
  parameter int SET_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             cnt_en,
  input  logic [SET_W-1:0] set_idx,
  output logic             trig,
  output logic [SET_W-1:0] trig_tgt
);
  localparam int N_SETS = 1 << SET_W;
  localparam logic [SET_W-1:0] LAST = SET_W'(N_SETS - 1);

  logic [1:0] cnt_q [N_SETS];
  logic [1:0] cnt_d [N_SETS];
  logic [1:0] c_s, c_lo, c_hi, inc;
  logic [2:0] sum_lo, sum_hi;
  logic [SET_W-1:0] s_lo, s_hi;

  assign s_lo = set_idx - SET_W'(1);
  assign s_hi = set_idx + SET_W'(1);

  always_comb begin
    cnt_d    = cnt_q;
    trig     = 1'b0;
    trig_tgt = '0;
    c_s      = cnt_q[set_idx];
    c_lo     = (set_idx != '0)  ? cnt_q[s_lo] : 2'd0;
    c_hi     = (set_idx != LAST) ? cnt_q[s_hi] : 2'd0;
    inc      = (c_s == 2'd3) ? 2'd3 : c_s + 2'd1;
    sum_lo   = {1'b0, inc} + {1'b0, c_lo};
    sum_hi   = {1'b0, inc} + {1'b0, c_hi};
    if (flush) begin
      for (int i = 0; i < N_SETS; i++) cnt_d[i] = 2'd0;
    end else if (cnt_en) begin
      if (inc == 2'd3 && set_idx != LAST) begin
        // same set saturated: next line after it
        trig = 1'b1; trig_tgt = s_hi; cnt_d[set_idx] = 2'd0;
      end else if (c_lo != 2'd0 && sum_lo >= 3'd3) begin
        // pair (set-1, set): next line after the lower set
        trig = 1'b1; trig_tgt = set_idx;
        cnt_d[set_idx] = 2'd0; cnt_d[s_lo] = 2'd0;
      end else if (c_hi != 2'd0 && sum_hi >= 3'd3) begin
        // pair (set, set+1)
        trig = 1'b1; trig_tgt = s_hi;
        cnt_d[set_idx] = 2'd0; cnt_d[s_hi] = 2'd0;
      end else begin
        cnt_d[set_idx] = inc;  // at the page edge this saturates silently
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_SETS; i++) cnt_q[i] <= 2'd0;
    end else if (flush || cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/pfx_page_tab.sv
// Fully associative table of tracked pages with round-robin replacement.
module pfx_page_tab #(
  parameter int N     = 4,
  parameter int PPN_W = 20,
  parameter int SET_W = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush,
  input  logic                      trk_en,
  input  logic                      kill_en,
  input  logic [PPN_W-1:0]          ppn,
  input  logic [SET_W-1:0]          set_idx,
  output logic [N-1:0]              nxt_vld,
  output logic [N-1:0][PPN_W-1:0]   nxt_ppn,
  output logic [N-1:0][SET_W-1:0]   nxt_last
);
  localparam int PTR_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]            vld_q;
  logic [N-1:0][PPN_W-1:0] ppn_q;
  logic [N-1:0][SET_W-1:0] last_q;
  logic [PTR_W-1:0]        ptr_q, ptr_d;
  logic [N-1:0]            hit;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit[g] = vld_q[g] && (ppn_q[g] == ppn);
  end

  always_comb begin
    nxt_vld  = vld_q;
    nxt_ppn  = ppn_q;
    nxt_last = last_q;
    ptr_d    = ptr_q;
    if (flush) begin
      nxt_vld = '0;
      ptr_d   = '0;
    end else if (kill_en) begin
      nxt_vld = vld_q & ~hit;
    end else if (trk_en) begin
      if (|hit) begin
        for (int i = 0; i < N; i++) if (hit[i]) nxt_last[i] = set_idx;
      end else begin
        nxt_vld[ptr_q]  = 1'b1;
        nxt_ppn[ptr_q]  = ppn;
        nxt_last[ptr_q] = set_idx;
        ptr_d = (ptr_q == PTR_W'(N - 1)) ? '0 : ptr_q + PTR_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      ppn_q  <= '0;
      last_q <= '0;
      ptr_q  <= '0;
    end else if (flush || kill_en || trk_en) begin
      vld_q  <= nxt_vld;
      ppn_q  <= nxt_ppn;
      last_q <= nxt_last;
      ptr_q  <= ptr_d;
    end
  end
endmodule

// File: rtl/pfx_issue.sv
// Holds one burst of next-line requests and offers them one per cycle.
module pfx_issue #(
  parameter int N     = 4,
  parameter int PPN_W = 20,
  parameter int SET_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     start,
  input  logic [N-1:0]             start_mask,
  input  logic [SET_W-1:0]         start_tgt,
  input  logic [N-1:0][PPN_W-1:0]  start_ppn,
  input  logic                     pf_ready,
  output logic                     pf_valid,
  output logic [PPN_W+SET_W-1:0]   pf_line
);
  localparam int SEL_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]            pend_q, pend_d;
  logic [N-1:0][PPN_W-1:0] ppn_q;
  logic [SET_W-1:0]        tgt_q;
  logic [SEL_W-1:0]        sel;
  logic                    busy, load;

  assign busy = |pend_q;
  assign load = start && !busy && !flush;

  always_comb begin
    sel = '0;
    for (int i = N - 1; i >= 0; i--) if (pend_q[i]) sel = SEL_W'(i);
  end

  always_comb begin
    pend_d = pend_q;
    if (flush)          pend_d = '0;
    else if (busy) begin
      if (pf_ready)     pend_d[sel] = 1'b0;
      else              pend_d = '0;       // refused: abandon the burst
    end else if (start) pend_d = start_mask;
  end

  assign pf_valid = busy;
  assign pf_line  = {ppn_q[sel], tgt_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ppn_q <= '0;
      tgt_q <= '0;
    end else if (load) begin
      ppn_q <= start_ppn;
      tgt_q <= start_tgt;
    end
  end
endmodule

// File: rtl/pg_nl_prefetch.sv
module pg_nl_prefetch #(
  parameter int PA_W    = 32,
  parameter int N_PAGES = 4,
  localparam int LA_W   = PA_W - pfx_pkg::LINE_OFS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            acc_valid,
  input  logic [1:0]      acc_kind,
  input  logic [LA_W-1:0] acc_line,
  input  logic            acc_dirty,
  input  logic            acc_wb,
  output logic            pf_valid,
  input  logic            pf_ready,
  output logic [LA_W-1:0] pf_line
);
  import pfx_pkg::*;
  localparam int SET_W = PAGE_OFS - LINE_OFS;
  localparam int PPN_W = PA_W - PAGE_OFS;

  logic [1:0] rst_sync;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  logic [PPN_W-1:0] acc_ppn;
  logic [SET_W-1:0] acc_set;
  logic             is_read, qual, kill;
  assign acc_ppn = acc_line[LA_W-1:SET_W];
  assign acc_set = acc_line[SET_W-1:0];
  assign is_read = (acc_kind == ACC_LOAD) || (acc_kind == ACC_SWPF);
  assign qual    = acc_valid && acc_wb && !acc_dirty && is_read;
  assign kill    = acc_valid && acc_wb && (acc_dirty || acc_kind == ACC_STORE);

  logic             trig;
  logic [SET_W-1:0] trig_tgt;
  logic [N_PAGES-1:0]             nxt_vld, mask;
  logic [N_PAGES-1:0][PPN_W-1:0]  nxt_ppn;
  logic [N_PAGES-1:0][SET_W-1:0]  nxt_last;

  pfx_set_ctrs #(.SET_W(SET_W)) u_ctrs (
    .clk(clk), .rst_n(rst_core_n), .flush(flush), .cnt_en(qual),
    .set_idx(acc_set), .trig(trig), .trig_tgt(trig_tgt)
  );

  pfx_page_tab #(.N(N_PAGES), .PPN_W(PPN_W), .SET_W(SET_W)) u_tab (
    .clk(clk), .rst_n(rst_core_n), .flush(flush), .trk_en(qual),
    .kill_en(kill), .ppn(acc_ppn), .set_idx(acc_set),
    .nxt_vld(nxt_vld), .nxt_ppn(nxt_ppn), .nxt_last(nxt_last)
  );

  // skip pages whose latest access already covers the target line
  for (genvar g = 0; g < N_PAGES; g++) begin : g_mask
    assign mask[g] = nxt_vld[g] && (nxt_last[g] != trig_tgt);
  end

  pfx_issue #(.N(N_PAGES), .PPN_W(PPN_W), .SET_W(SET_W)) u_iss (
    .clk(clk), .rst_n(rst_core_n), .flush(flush), .start(trig),
    .start_mask(mask), .start_tgt(trig_tgt), .start_ppn(nxt_ppn),
    .pf_ready(pf_ready), .pf_valid(pf_valid), .pf_line(pf_line)
  );
endmodule

// File: rtl/pfx_checker.sv
module pfx_checker #(
  parameter int LA_W = 26
) (
  input logic            clk,
  input logic            rst_n,
  input logic            flush,
  input logic            acc_valid,
  input logic            acc_wb,
  input logic            pf_valid,
  input logic            pf_ready,
  input logic [LA_W-1:0] pf_line
);
  // R4: target set is always a following line, never line 0 of a page
  a_r4_no_page_cross: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> (pf_line[5:0] != 6'd0));

  // R10: a flush leaves nothing on offer in the next cycle
  a_r10_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !pf_valid);

  // R9: a refused request ends the burst
  a_r9_refuse_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready) |=> !pf_valid);

  // R3: an accepted request is followed by a different line or nothing
  a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && pf_ready) |=> (!pf_valid || pf_line != $past(pf_line)));

  // R7: a non-write-back access cannot start a burst
  a_r7_nonwb_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_wb && !pf_valid) |=> !pf_valid);
endmodule

bind pg_nl_prefetch pfx_checker #(.LA_W(LA_W)) u_pfx_checker (
  .clk(clk), .rst_n(rst_n), .flush(flush), .acc_valid(acc_valid),
  .acc_wb(acc_wb), .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_line(pf_line)
);

// File: tb/test_pg_nl_prefetch.sv
`timescale 1ns/1ps
module test_pg_nl_prefetch;
  localparam int PA_W = 32;
  localparam int LA_W = PA_W - 6;
  localparam logic [1:0] K_LD = 2'd0, K_SW = 2'd1, K_ST = 2'd2, K_OT = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic acc_valid = 1'b0, acc_dirty = 1'b0, acc_wb = 1'b1, pf_ready = 1'b1;
  logic [1:0] acc_kind = 2'd0;
  logic [LA_W-1:0] acc_line = '0;
  logic pf_valid;
  logic [LA_W-1:0] pf_line;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  pg_nl_prefetch #(.PA_W(PA_W), .N_PAGES(4)) i_pg_nl_prefetch (
    .clk(clk), .rst_n(rst_n), .flush(flush), .acc_valid(acc_valid),
    .acc_kind(acc_kind), .acc_line(acc_line), .acc_dirty(acc_dirty),
    .acc_wb(acc_wb), .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_line(pf_line)
  );

  function automatic logic [LA_W-1:0] la(input logic [19:0] ppn, input int set);
    return {ppn, 6'(set)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [LA_W:0] act, input logic [LA_W:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one access on a falling edge; returns at the next falling edge
  task automatic acc(input logic [1:0] k, input logic [19:0] ppn, input int set,
                     input logic dirty = 1'b0, input logic wb = 1'b1);
    acc_valid = 1'b1; acc_kind = k; acc_line = la(ppn, set);
    acc_dirty = dirty; acc_wb = wb;
    @(negedge clk);
    acc_valid = 1'b0; acc_dirty = 1'b0; acc_wb = 1'b1;
  endtask

  task automatic do_flush();
    flush = 1'b1; @(negedge clk); flush = 1'b0;
  endtask

  task automatic exp_req(input string req, input logic [LA_W-1:0] line);
    check(pf_valid === 1'b1 && pf_line === line, req, {pf_valid, pf_line}, {1'b1, line});
    @(negedge clk);
  endtask

  task automatic exp_none(input string req, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      check(pf_valid === 1'b0, req, {pf_valid, pf_line}, '0);
      @(negedge clk);
    end
  endtask

  localparam logic [19:0] PA = 20'hF1, PB = 20'hF2, PC = 20'hF3, PD = 20'hF4,
                          PE = 20'hF5, PF = 20'hF6, PG = 20'hF7;

  task automatic t_reset();
    exp_none("R1 idle after reset", 2);
  endtask

  task automatic t_same_set();
    acc(K_LD, PA, 5); exp_none("R2 one access", 1);
    acc(K_SW, PA, 5); exp_none("R2 two accesses", 1);
    acc(K_LD, PA, 5);
    exp_req("R2 third access triggers", la(PA, 6));
    exp_none("R2 single page burst ends", 1);
  endtask

  task automatic t_fanout();
    acc(K_LD, PB, 10); acc(K_LD, PC, 10); acc(K_LD, PD, 10);
    exp_req("R3 entry0", la(PA, 11));
    exp_req("R3 entry1", la(PB, 11));
    exp_req("R3 entry2", la(PC, 11));
    exp_req("R3 entry3", la(PD, 11));
    exp_none("R3 burst ends", 1);
  endtask

  task automatic t_round_robin();
    acc(K_LD, PE, 12); acc(K_LD, PE, 12); acc(K_LD, PE, 12);
    exp_req("R6 new page replaces entry0", la(PE, 13));
    exp_req("R6 entry1 kept", la(PB, 13));
    exp_req("R6 entry2 kept", la(PC, 13));
    exp_req("R6 entry3 kept", la(PD, 13));
    exp_none("R6 burst ends", 1);
  endtask

  task automatic t_page_edge();
    acc(K_LD, PF, 63); acc(K_LD, PF, 63); acc(K_LD, PF, 63);
    exp_none("R4 last line of page", 3);
    do_flush();
  endtask

  task automatic t_ignored();
    do_flush();
    acc(K_LD, PA, 20); acc(K_LD, PA, 20);
    acc(K_LD, PC, 20, 1'b1, 1'b1);   // dirty
    acc(K_LD, PD, 20, 1'b0, 1'b0);   // not write-back
    acc(K_OT, PG, 20);               // other kind
    exp_none("R7 ignored accesses do not count", 1);
    acc(K_LD, PB, 20);
    exp_req("R7 count was two before", la(PA, 21));
    exp_req("R7 dirty/non-wb pages not inserted", la(PB, 21));
    exp_none("R7 only two pages tracked", 1);
  endtask

  task automatic t_store_kill();
    acc(K_ST, PA, 30);
    acc(K_LD, PB, 30); acc(K_LD, PB, 30); acc(K_LD, PB, 30);
    exp_req("R8 store untracks page", la(PB, 31));
    exp_none("R8 stored page absent", 1);
  endtask

  task automatic t_pair();
    do_flush();
    acc(K_LD, PD, 40);
    acc(K_LD, PA, 1); acc(K_LD, PB, 1);
    acc(K_LD, PC, 0);
    exp_req("R5 pair trigger entry0", la(PD, 1));
    exp_req("R5 pages on target line skipped", la(PC, 1));
    exp_none("R5 burst ends", 1);
  endtask

  task automatic t_refuse();
    do_flush();
    acc(K_LD, PA, 2); acc(K_LD, PB, 2);
    pf_ready = 1'b0;
    acc(K_LD, PC, 2);
    check(pf_valid === 1'b1 && pf_line === la(PA, 3), "R9 first offered",
          {pf_valid, pf_line}, {1'b1, la(PA, 3)});
    @(negedge clk);
    pf_ready = 1'b1;
    exp_none("R9 refused burst dropped", 2);
  endtask

  task automatic t_flush();
    do_flush();
    acc(K_LD, PA, 7); acc(K_LD, PA, 7);
    do_flush();
    acc(K_LD, PA, 7); exp_none("R10 counter cleared by flush", 1);
    acc(K_LD, PA, 7); exp_none("R10 counter cleared by flush", 1);
    acc(K_LD, PA, 7);
    exp_req("R10 counting restarts", la(PA, 8));
    exp_none("R10 table cleared by flush", 1);
    acc(K_LD, PB, 9); acc(K_LD, PB, 9); acc(K_LD, PB, 9);
    do_flush();
    exp_none("R10 flush cancels burst", 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_same_set();
    t_fanout();
    t_round_robin();
    t_page_edge();
    t_ignored();
    t_store_kill();
    t_pair();
    t_refuse();
    t_flush();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule